// File: doc/BRIEF.md
# ISA I/O Port Access Snooper

This block is a passive observer that sits beside a real disk controller on an ISA-style I/O bus. It samples the bus address lines, the 8-bit data lines and the two active-low I/O strobes into a fast system clock. It recognises accesses to the primary disk-controller register window (0x1F0 to 0x1F7) and to the alternate status/control port at 0x3F6. It never drives the bus.

For each recognised access it builds one 16-bit record and appends it to an on-chip log. The record holds the data byte, four address bits and the raw levels of both strobes. Software can therefore pick out reads, writes and malformed captures afterwards. A read port returns any record by index. A clear input empties the log and resets the status flags.

The log keeps its contents once it is full. Accesses that arrive after that point are counted rather than stored.

Top module: `isa_port_snooper`

## Requirements
- R1: After reset, `entryCount` is 0, `fullFlag` is 0, `errFlag` is 0 and `overflowCount` is 0.
- R2: Each address bit A8 down to A4 must be 1 and A3 must be 0. With A9 = 0, every address 0x1F0–0x1F7 matches. Address bits above A9 play no part in the decode, so 0x9F3 matches like 0x1F3. Addresses 0x1E0 (A4 low) and 0x1F8 (A3 high) do not match.
- R3: With A9 = 1, A2 and A1 must both be 1, and A0 is not decoded. Both 0x3F6 and 0x3F7 match. Addresses 0x3F4 (A1 low) and 0x3F0 (A2 and A1 low) do not match.
- R4: A matching address with both `iorN` and `iowN` high is not logged.
- R5: A stored record has this layout. Bits 7:0 hold the data bus. Bit 11 holds A9, bit 10 holds A2, bit 9 holds A1 and bit 8 holds A0. Bit 12 holds the raw `iowN` level and bit 13 holds the raw `iorN` level. Bits 15:14 are 0. Field {bit13, bit12} = 01 is a read and 10 is a write. For example, 0x3F6 gives address nibble 0xE.
- R6: Exactly one record is stored per select assertion, however long the strobe is held. `entryCount` rises by one per stored record.
- R7: The record is taken `SETTLE` system clocks after the synchronized select is first seen. Data that changes one clock after the strobe falls is therefore captured at its later value.
- R8: A capture whose strobe field is 00 or 11 is still stored, with its raw levels. It also sets the sticky `errFlag`. Captures with a valid field leave `errFlag` at 0.
- R9: Once `DEPTH` records are stored, `fullFlag` goes to 1. Later accesses are not stored and `entryCount` stays at `DEPTH`. Each such access adds one to `overflowCount`, which saturates.
- R10: `rdWord` shows the record at `rdIndex` one clock after `rdIndex` is applied.
- R11: A one-clock pulse on `clearReq` returns `entryCount`, `fullFlag`, `errFlag` and `overflowCount` to 0. The next capture is then stored at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus address lines (bits 15:10 are not decoded) |
| busData | input | 8 | Bus data lines |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| clearReq | input | 1 | Clears pointer, flags and overflow count |
| rdIndex | input | 10 | Log index to read back |
| rdWord | output | 16 | Record at `rdIndex`, one clock later |
| entryCount | output | 11 | Number of stored records |
| fullFlag | output | 1 | Sticky: log has reached `DEPTH` records |
| errFlag | output | 1 | Sticky: a record with strobe field 00 or 11 was stored |
| overflowCount | output | 16 | Accesses missed while full, saturating |

## Verification
The window decode is tested at addresses just outside each boundary. A decoder that drops A3, A4 or the A9-qualified A2/A1 terms would log 0x1F8, 0x1E0, 0x3F4 or 0x3F0. A decoder that decodes A0 would lose the 0x3F7 alias.

A strobe held for many clocks exposes an edge detector that logs every cycle. Changing the data one clock after the strobe falls exposes sampling that happens too early.

Both strobes active together check that a malformed capture is kept and flagged, not dropped. Filling all 1024 entries and then sending further accesses exposes an off-by-one in the full point, a pointer that wraps onto old records, and an overflow count that misses accesses.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  // Strobes from the capture control to the datapath.
  typedef struct packed {
    logic capture;   // take one record this cycle
    logic clearAll;  // reset pointer, flags, overflow count
  } snoopCmd_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } snoopState_t;
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode #(
  parameter int DEC_W = 10
) (
  input  logic [DEC_W-1:0] addrIn,
  input  logic             iorN,
  input  logic             iowN,
  output logic             addrHit,
  output logic             selHit
);
  logic baseHit;
  logic highOk;

  // A8..A4 high, A3 low; with A9 high, A2 and A1 must also be high.
  always_comb begin
    baseHit = (&addrIn[8:4]) && !addrIn[3];
    highOk  = !addrIn[9] || (addrIn[2] && addrIn[1]);
    addrHit = baseHit && highOk;
    selHit  = addrHit && (!iorN || !iowN);
  end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selHit,
  input  logic      clearReq,
  output snoopCmd_t cmd
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE - 1);

  snoopState_t     state;
  logic [CNT_W-1:0] waitCnt;
  logic            selPrev;
  logic            selRise;
  logic            fire;

  always_comb begin
    selRise      = selHit && !selPrev;
    fire         = (state == ST_WAIT) && (waitCnt == '0) && !clearReq;
    cmd.capture  = fire;
    cmd.clearAll = clearReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      selPrev <= 1'b0;
    end else begin
      selPrev <= selHit;
      if (clearReq) begin
        state   <= ST_IDLE;
        waitCnt <= '0;
      end else begin
        case (state)
          ST_IDLE: if (selRise) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_LOAD;
          end
          ST_WAIT: begin
            if (waitCnt == '0) state <= ST_IDLE;
            else               waitCnt <= waitCnt - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7: while waiting, the settle countdown steps by one each clock
  a_r7_settle_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && waitCnt != '0 && !clearReq)
      |=> (state == ST_WAIT && waitCnt == $past(waitCnt) - 1'b1));

  // R6: a capture is never issued on two adjacent clocks
  a_r6_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    cmd.capture |=> !cmd.capture);
endmodule

// File: rtl/snoop_path.sv
module snoop_path
  import snoop_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int OVF_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [9:0]               busAddrLow,
  input  logic [DATA_W-1:0]        busData,
  input  logic                     iorN,
  input  logic                     iowN,
  input  snoopCmd_t                cmd,
  input  logic [$clog2(DEPTH)-1:0] rdIndex,
  output logic                     selHit,
  output logic [BUS_W-1:0]         rdWord,
  output logic [$clog2(DEPTH):0]   entryCount,
  output logic                     fullFlag,
  output logic                     errFlag,
  output logic [OVF_W-1:0]         overflowCount
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int RAW_W = 10 + DATA_W + 2;
  localparam int PAD_W = BUS_W - DATA_W - 6;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  // Synchronizer chain: {iorN, iowN, addr[9:0], data}
  logic [RAW_W-1:0] syncStage [SYNC_N];
  logic [RAW_W-1:0] rawIn;
  logic [RAW_W-1:0] syncOut;

  assign rawIn = {iorN, iowN, busAddrLow, busData};

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_N; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[gi] <= {2'b11, {(RAW_W-2){1'b0}}};
        else if (gi == 0) syncStage[gi] <= rawIn;
        else syncStage[gi] <= syncStage[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign syncOut = syncStage[SYNC_N-1];

  logic              sIorN;
  logic              sIowN;
  logic [9:0]        sAddr;
  logic [DATA_W-1:0] sData;
  logic              addrHit;

  assign sIorN = syncOut[RAW_W-1];
  assign sIowN = syncOut[RAW_W-2];
  assign sAddr = syncOut[DATA_W +: 10];
  assign sData = syncOut[DATA_W-1:0];

  snoop_decode #(.DEC_W(10)) u_decode (
    .addrIn (sAddr),
    .iorN   (sIorN),
    .iowN   (sIowN),
    .addrHit(addrHit),
    .selHit (selHit)
  );

  // Record assembly
  logic [BUS_W-1:0] newWord;
  logic             badMode;

  always_comb begin
    newWord = {{PAD_W{1'b0}}, sIorN, sIowN,
               sAddr[9], sAddr[2], sAddr[1], sAddr[0], sData};
    badMode = (sIorN == sIowN);
  end

  // Log storage
  logic [BUS_W-1:0] logMem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtr;
  logic             isFull;
  logic             doWrite;

  assign wrPtr   = count[PTR_W-1:0];
  assign isFull  = (count == CNT_FULL);
  assign doWrite = cmd.capture && !cmd.clearAll && !isFull;

  always_ff @(posedge clk) begin
    if (doWrite) logMem[wrPtr] <= newWord;
    rdWord <= logMem[rdIndex];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count         <= '0;
      fullFlag      <= 1'b0;
      errFlag       <= 1'b0;
      overflowCount <= '0;
    end else if (cmd.clearAll) begin
      count         <= '0;
      fullFlag      <= 1'b0;
      errFlag       <= 1'b0;
      overflowCount <= '0;
    end else if (cmd.capture) begin
      if (isFull) begin
        if (overflowCount != '1) overflowCount <= overflowCount + 1'b1;
      end else begin
        count <= count + 1'b1;
        if (count == CNT_FULL - 1'b1) fullFlag <= 1'b1;
        if (badMode) errFlag <= 1'b1;
      end
    end
  end

  assign entryCount = count;

  // R9: once full, the count stays at the depth until a clear
  a_r9_hold_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && !cmd.clearAll) |=> (entryCount == CNT_FULL && fullFlag));

  // R8: the error flag stays set until a clear
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !cmd.clearAll) |=> errFlag);

  // R11: a clear empties the log state on the next clock
  a_r11_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (entryCount == '0 && !fullFlag && !errFlag
                      && overflowCount == '0));

  // R6: the count advances by at most one per clock
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.clearAll |=> (entryCount == $past(entryCount)
                       || entryCount == $past(entryCount) + 1'b1));
endmodule

// File: rtl/isa_port_snooper.sv
module isa_port_snooper
  import snoop_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int OVF_W  = 16,
  parameter int SYNC_N = 2,
  parameter int SETTLE = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [15:0]              busAddr,
  input  logic [DATA_W-1:0]        busData,
  input  logic                     iorN,
  input  logic                     iowN,
  input  logic                     clearReq,
  input  logic [$clog2(DEPTH)-1:0] rdIndex,
  output logic [BUS_W-1:0]         rdWord,
  output logic [$clog2(DEPTH):0]   entryCount,
  output logic                     fullFlag,
  output logic                     errFlag,
  output logic [OVF_W-1:0]         overflowCount
);
  snoopCmd_t cmd;
  logic      selHit;
  logic      unusedHighAddr;

  // Address bits above A9 are deliberately not decoded.
  assign unusedHighAddr = ^busAddr[15:10];

  snoop_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selHit  (selHit),
    .clearReq(clearReq),
    .cmd     (cmd)
  );

  snoop_path #(
    .BUS_W (BUS_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .OVF_W (OVF_W),
    .SYNC_N(SYNC_N)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .busAddrLow   (busAddr[9:0]),
    .busData      (busData),
    .iorN         (iorN),
    .iowN         (iowN),
    .cmd          (cmd),
    .rdIndex      (rdIndex),
    .selHit       (selHit),
    .rdWord       (rdWord),
    .entryCount   (entryCount),
    .fullFlag     (fullFlag),
    .errFlag      (errFlag),
    .overflowCount(overflowCount)
  );
endmodule

// File: tb/isa_port_snooper_tb.sv
module isa_port_snooper_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic        iorN = 1'b1;
  logic        iowN = 1'b1;
  logic        clearReq = 1'b0;
  logic [9:0]  rdIndex = '0;
  logic [15:0] rdWord;
  logic [10:0] entryCount;
  logic        fullFlag;
  logic        errFlag;
  logic [15:0] overflowCount;

  int nChecks = 0;
  int nFails  = 0;
  int expCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  isa_port_snooper u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData),
    .iorN(iorN), .iowN(iowN), .clearReq(clearReq), .rdIndex(rdIndex),
    .rdWord(rdWord), .entryCount(entryCount), .fullFlag(fullFlag),
    .errFlag(errFlag), .overflowCount(overflowCount)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input logic [15:0] a, input logic [7:0] d,
                                         input logic r, input logic w);
    return {2'b00, r, w, a[9], a[2], a[1], a[0], d};
  endfunction

  // One bus access: strobes held for 'hold' clocks, then a gap.
  task automatic busCycle(input logic [15:0] a, input logic [7:0] d,
                          input logic r, input logic w, input int hold);
    @(negedge clk);
    busAddr = a; busData = d; iorN = r; iowN = w;
    repeat (hold) @(negedge clk);
    iorN = 1'b1; iowN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic readWord(input int idx, output logic [15:0] w);
    @(negedge clk);
    rdIndex = 10'(idx);
    @(negedge clk);
    w = rdWord;
  endtask

  task automatic pulseClear();
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
    expCount = 0;
  endtask

  // Access that must be logged; checks count and stored word.
  task automatic expectLogged(input string tag, input logic [15:0] a, input logic [7:0] d,
                              input logic r, input logic w);
    logic [15:0] got;
    busCycle(a, d, r, w, 12);
    expCount++;
    check({tag, " count"}, 32'(entryCount), 32'(expCount));
    readWord(expCount - 1, got);
    check({tag, " word"}, 32'(got), 32'(mkWord(a, d, r, w)));
  endtask

  task automatic expectIgnored(input string tag, input logic [15:0] a, input logic r, input logic w);
    busCycle(a, 8'h3C, r, w, 12);
    check(tag, 32'(entryCount), 32'(expCount));
  endtask

  task automatic t_reset();
    check("R1 count", 32'(entryCount), 0);
    check("R1 full", 32'(fullFlag), 0);
    check("R1 err", 32'(errFlag), 0);
    check("R1 overflow", 32'(overflowCount), 0);
  endtask

  task automatic t_window();
    expectLogged("R2 0x1F0 write", 16'h01F0, 8'hA5, 1'b1, 1'b0);
    expectLogged("R2 0x1F7 read", 16'h01F7, 8'h50, 1'b0, 1'b1);
    expectLogged("R2 high alias 0x9F3", 16'h09F3, 8'h11, 1'b1, 1'b0);
    expectIgnored("R2 0x1E0 ignored", 16'h01E0, 1'b1, 1'b0);
    expectIgnored("R2 0x1F8 ignored", 16'h01F8, 1'b0, 1'b1);
  endtask

  task automatic t_split_port();
    expectLogged("R3 0x3F6 write", 16'h03F6, 8'h04, 1'b1, 1'b0);
    expectLogged("R3 0x3F7 alias", 16'h03F7, 8'h7E, 1'b0, 1'b1);
    expectIgnored("R3 0x3F4 ignored", 16'h03F4, 1'b1, 1'b0);
    expectIgnored("R3 0x3F0 ignored", 16'h03F0, 1'b0, 1'b1);
  endtask

  task automatic t_no_strobe();
    expectIgnored("R4 no strobe", 16'h01F2, 1'b1, 1'b1);
  endtask

  task automatic t_layout();
    logic [15:0] got;
    busCycle(16'h03F6, 8'hC3, 1'b0, 1'b1, 12);
    expCount++;
    readWord(expCount - 1, got);
    check("R5 nibble 0x3F6", 32'(got[11:8]), 32'hE);
    check("R5 read mode bits", 32'(got[13:12]), 32'h1);
    check("R5 upper zero", 32'(got[15:14]), 0);
    check("R5 data", 32'(got[7:0]), 32'hC3);
  endtask

  task automatic t_one_per_assert();
    busCycle(16'h01F4, 8'h55, 1'b1, 1'b0, 60);
    expCount++;
    check("R6 long strobe one entry", 32'(entryCount), 32'(expCount));
  endtask

  task automatic t_settle();
    logic [15:0] got;
    @(negedge clk);
    busAddr = 16'h01F5; busData = 8'h01; iowN = 1'b0;
    @(negedge clk);
    busData = 8'hBE;
    repeat (12) @(negedge clk);
    iowN = 1'b1;
    repeat (5) @(negedge clk);
    expCount++;
    readWord(expCount - 1, got);
    check("R7 settled data", 32'(got), 32'(mkWord(16'h01F5, 8'hBE, 1'b1, 1'b0)));
  endtask

  task automatic t_invalid();
    check("R8 err clear before", 32'(errFlag), 0);
    expectLogged("R8 both strobes", 16'h01F1, 8'h99, 1'b0, 1'b0);
    check("R8 err set", 32'(errFlag), 1);
  endtask

  task automatic t_full();
    logic [15:0] got;
    pulseClear();
    for (int i = 0; i < 1024; i++) begin
      busCycle(16'h01F0 | 16'(i % 8), 8'(i), 1'b1, 1'b0, 9);
      if (i == 1022) check("R9 not full at 1023", 32'(fullFlag), 0);
    end
    expCount = 1024;
    check("R9 full flag", 32'(fullFlag), 1);
    check("R9 count at depth", 32'(entryCount), 1024);
    for (int k = 0; k < 3; k++) busCycle(16'h01F6, 8'hEE, 1'b1, 1'b0, 9);
    check("R9 count held", 32'(entryCount), 1024);
    check("R9 overflow count", 32'(overflowCount), 3);
    readWord(1023, got);
    check("R10 last entry", 32'(got), 32'(mkWord(16'h01F7, 8'hFF, 1'b1, 1'b0)));
    readWord(0, got);
    check("R10 first entry kept", 32'(got), 32'(mkWord(16'h01F0, 8'h00, 1'b1, 1'b0)));
  endtask

  task automatic t_clear();
    pulseClear();
    check("R11 count", 32'(entryCount), 0);
    check("R11 full", 32'(fullFlag), 0);
    check("R11 overflow", 32'(overflowCount), 0);
    expectLogged("R11 index zero after clear", 16'h01F3, 8'h42, 1'b1, 1'b0);
    busCycle(16'h01F2, 8'h00, 1'b0, 1'b0, 12);
    expCount++;
    pulseClear();
    check("R11 err cleared", 32'(errFlag), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_split_port();
    t_no_strobe();
    t_layout();
    t_one_per_assert();
    t_settle();
    t_invalid();
    t_full();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule